// File: doc/BRIEF.md
# Sponge Absorb Unit with Rate-Boundary Carry

This unit feeds message bytes into the rate part of a 1600-bit sponge state. Data arrives as 256-bit stream beats with a per-byte keep mask. The valid bytes of each accepted beat are XORed into the state at the current byte position. When that position reaches the rate of the selected hash mode, the unit raises a permutation request and drops ready. It then waits for the external permutation to hand back the permuted state. A beat that runs past the end of the rate block is split. The bytes that fit are absorbed at once. The rest are parked in a carry buffer and XORed into bytes 0 and up of the new block in the same cycle the permuted state is loaded. The sender therefore never has to align a beat to a block edge.

A start pulse latches the 2-bit mode, clears the state and the position, and opens the sink. When the beat flagged as last has been absorbed, and any permutation it caused has completed, the unit raises a done flag. It also holds the byte position where the padding stage must put its first padding byte. The unit does no padding, no permutation and no output.

Top module: `sponge_absorb_unit`

## Requirements
- R1: While reset is high and after it is released, ready, permutation request and done are all low until a start pulse arrives.
- R2: A start pulse, in any phase and even mid-message, clears all 1600 state bits and the byte position to zero, latches the mode and raises ready in the next cycle; later changes of the mode input have no effect until the next start.
- R3: An accepted beat XORs its N valid bytes into state bytes P..P+N-1, where P is the current byte position and N is the number of set keep bits; keep bit i qualifies data bits 8i+7..8i, state byte k occupies state bits 8k+7..8k, and data bytes whose keep bit is clear leave the state unchanged.
- R4: The rate block is 136 bytes for mode 0, 72 bytes for mode 1, 168 bytes for mode 2 and 136 bytes for mode 3; state bytes at or above the rate are never written by a beat.
- R5: A beat is taken only on a clock edge where valid and ready are both high; otherwise the state and byte position stay unchanged, including while valid is held high during a permutation.
- R6: When an accepted beat brings the position to or past the rate, the permutation request is high from the next cycle and ready stays low until the permutation-done pulse.
- R7: Bytes of a beat that lie past the rate boundary are XORed into state bytes 0 and up of the new block together with the permuted state on the done pulse, and the byte position becomes their count.
- R8: After a last beat that does not fill the block, done goes high and ready low in the next cycle, with the byte position equal to the total fill of the block; done stays high until the next start.
- R9: A last beat that ends exactly on the rate boundary requests a permutation, and after it done goes high with a byte position of zero.
- R10: A last beat that crosses the rate boundary requests a permutation, and after it done goes high with the carried bytes merged and the byte position equal to their count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a new message |
| mode_i | input | 2 | Hash mode, sampled on start (0..3) |
| s_tdata_i | input | 256 | Message beat, byte 0 in bits 7..0 |
| s_tkeep_i | input | 32 | Byte qualifiers, contiguous from bit 0 |
| s_tvalid_i | input | 1 | Beat valid |
| s_tlast_i | input | 1 | Beat is the final message fragment |
| s_tready_o | output | 1 | Unit can take a beat |
| perm_req_o | output | 1 | Rate block full, permutation requested |
| perm_done_i | input | 1 | One-cycle pulse, permuted state is on perm_state_i |
| perm_state_i | input | 1600 | Permuted state returned by the permutation |
| state_o | output | 1600 | Current sponge state |
| msg_done_o | output | 1 | Message fully absorbed |
| byte_pos_o | output | 8 | Fill position in the current block; padding offset when done |

## Verification
A beat that crosses the rate boundary and carries the last flag triggers carry capture, the permutation request and end-of-message reporting all on one edge. The permuted-state load and the carry merge then land in the same later cycle. The bench provokes this by sweeping every beat width from 1 to 32 bytes in all four modes. For each width it sends message lengths equal to the rate, to the first multiple of the width at or past the rate, and to twice the rate plus five. The permutation stand-in returns the bitwise inverse of the state. A byte-level model is checked against the full state, the byte position, done and ready after the load. The same model also checks the case where the exact boundary coincides with the last flag and the reported position must be zero.

// File: rtl/sab_pkg.sv
package sab_pkg;

   typedef enum logic [1:0] {
      SAB_IDLE = 2'd0,
      SAB_FILL = 2'd1,
      SAB_PERM = 2'd2,
      SAB_DONE = 2'd3
   } sab_phase_e;

endpackage

// File: rtl/sab_rate_sel.sv
module sab_rate_sel #(
   parameter int unsigned RB0 = 136,
   parameter int unsigned RB1 = 72,
   parameter int unsigned RB2 = 168,
   parameter int unsigned RB3 = 136,
   parameter int unsigned PW  = 8
) (
   input  logic [1:0]    mode_i,
   output logic [PW-1:0] rate_o
);

   always_comb begin
      unique case (mode_i)
         2'd0:    rate_o = PW'(RB0);
         2'd1:    rate_o = PW'(RB1);
         2'd2:    rate_o = PW'(RB2);
         default: rate_o = PW'(RB3);
      endcase
   end

endmodule

// File: rtl/sab_lane_xor.sv
module sab_lane_xor #(
   parameter int unsigned SB = 200,
   parameter int unsigned DB = 32,
   parameter int unsigned PW = 8
) (
   input  logic [SB*8-1:0] st_i,
   input  logic [DB*8-1:0] dat_i,
   input  logic [DB-1:0]   keep_i,
   input  logic [PW-1:0]   pos_i,
   input  logic [PW-1:0]   rate_i,
   output logic [SB*8-1:0] st_o,
   output logic [DB*8-1:0] carry_o
);

   localparam int unsigned IW = (DB > 1) ? $clog2(DB) : 1;

   // one lane per state byte: picks the beat byte that lands here, if any
   for (genvar b = 0; b < SB; b++) begin : g_lane
      logic [PW:0]   off;
      logic [IW-1:0] idx;
      logic          hit;
      logic [7:0]    nb;
      always_comb begin
         off = (PW+1)'(b) - {1'b0, pos_i};
         idx = off[IW-1:0];
         hit = (PW'(b) >= pos_i) && (PW'(b) < rate_i) &&
               (off < (PW+1)'(DB)) && keep_i[idx];
         nb  = st_i[b*8 +: 8] ^ (hit ? dat_i[idx*8 +: 8] : 8'h00);
      end
      assign st_o[b*8 +: 8] = nb;
   end

   // one slot per carry byte: beat bytes past the rate boundary, realigned to 0
   for (genvar j = 0; j < DB; j++) begin : g_carry
      logic [PW:0]   src;
      logic [IW-1:0] sidx;
      logic          take;
      logic [7:0]    cb;
      always_comb begin
         src  = {1'b0, rate_i} - {1'b0, pos_i} + (PW+1)'(j);
         sidx = src[IW-1:0];
         take = (src < (PW+1)'(DB)) && keep_i[sidx];
         cb   = take ? dat_i[sidx*8 +: 8] : 8'h00;
      end
      assign carry_o[j*8 +: 8] = cb;
   end

endmodule

// File: rtl/sab_ctrl.sv
module sab_ctrl
   import sab_pkg::*;
#(
   parameter int unsigned DB = 32,
   parameter int unsigned PW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_i,
   input  logic          valid_i,
   input  logic          last_i,
   input  logic [DB-1:0] keep_i,
   input  logic          perm_done_i,
   input  logic [PW-1:0] rate_i,
   output logic          ready_o,
   output logic          perm_req_o,
   output logic          done_o,
   output logic [PW-1:0] pos_o,
   output logic          absorb_o,
   output logic          load_o
);

   localparam int unsigned CW = $clog2(DB + 1);

   sab_phase_e    phase_q;
   logic [PW-1:0] pos_q;
   logic          last_pend_q;
   logic [CW-1:0] nbytes;
   logic [PW:0]   sum;
   logic          full;

   always_comb begin
      nbytes = '0;
      for (int i = 0; i < DB; i++) nbytes = nbytes + CW'(keep_i[i]);
   end

   assign sum        = {1'b0, pos_q} + (PW+1)'(nbytes);
   assign full       = (sum >= {1'b0, rate_i});
   assign ready_o    = (phase_q == SAB_FILL);
   assign perm_req_o = (phase_q == SAB_PERM);
   assign done_o     = (phase_q == SAB_DONE);
   assign pos_o      = pos_q;
   assign absorb_o   = valid_i && ready_o && !start_i;
   assign load_o     = perm_done_i && perm_req_o && !start_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q     <= SAB_IDLE;
         pos_q       <= '0;
         last_pend_q <= 1'b0;
      end else if (start_i) begin
         phase_q     <= SAB_FILL;
         pos_q       <= '0;
         last_pend_q <= 1'b0;
      end else begin
         unique case (phase_q)
            SAB_FILL: begin
               if (absorb_o) begin
                  if (full) begin
                     pos_q       <= PW'(sum - {1'b0, rate_i});
                     last_pend_q <= last_i;
                     phase_q     <= SAB_PERM;
                  end else begin
                     pos_q <= PW'(sum);
                     if (last_i) phase_q <= SAB_DONE;
                  end
               end
            end
            SAB_PERM: begin
               if (load_o) phase_q <= last_pend_q ? SAB_DONE : SAB_FILL;
            end
            default: ;
         endcase
      end
   end

   assert_perm_blocks_ready_R6: assert property (@(posedge clk) disable iff (rst)
      perm_req_o |-> !ready_o);

   assert_pos_below_rate_R4: assert property (@(posedge clk) disable iff (rst)
      (phase_q != SAB_IDLE) |-> (pos_q < rate_i));

   assert_full_requests_perm_R6: assert property (@(posedge clk) disable iff (rst)
      (absorb_o && full) |=> perm_req_o);

   assert_last_ends_msg_R8: assert property (@(posedge clk) disable iff (rst)
      (absorb_o && last_i && !full) |=> done_o);

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/sponge_absorb_unit.sv
module sponge_absorb_unit #(
   parameter int unsigned DATA_W  = 256,
   parameter int unsigned STATE_W = 1600,
   parameter int unsigned RATE_B0 = 136,
   parameter int unsigned RATE_B1 = 72,
   parameter int unsigned RATE_B2 = 168,
   parameter int unsigned RATE_B3 = 136
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               start_i,
   input  logic [1:0]                         mode_i,
   input  logic [DATA_W-1:0]                  s_tdata_i,
   input  logic [DATA_W/8-1:0]                s_tkeep_i,
   input  logic                               s_tvalid_i,
   input  logic                               s_tlast_i,
   output logic                               s_tready_o,
   output logic                               perm_req_o,
   input  logic                               perm_done_i,
   input  logic [STATE_W-1:0]                 perm_state_i,
   output logic [STATE_W-1:0]                 state_o,
   output logic                               msg_done_o,
   output logic [$clog2(STATE_W/8+1)-1:0]     byte_pos_o
);

   localparam int unsigned DB = DATA_W / 8;
   localparam int unsigned SB = STATE_W / 8;
   localparam int unsigned PW = $clog2(SB + 1);

   if (DATA_W % 8 != 0) begin : g_bad_dw
      $error("DATA_W must be a whole number of bytes");
   end
   if (STATE_W % 8 != 0 || STATE_W <= DATA_W) begin : g_bad_sw
      $error("STATE_W must be whole bytes and wider than DATA_W");
   end
   if (RATE_B0 < DB || RATE_B1 < DB || RATE_B2 < DB || RATE_B3 < DB) begin : g_bad_rmin
      $error("every rate must hold at least one full beat");
   end
   if (RATE_B0 > SB || RATE_B1 > SB || RATE_B2 > SB || RATE_B3 > SB) begin : g_bad_rmax
      $error("no rate may exceed the state");
   end

   logic [1:0]         mode_q;
   logic [PW-1:0]      rate_b;
   logic [STATE_W-1:0] st_q;
   logic [STATE_W-1:0] st_mix;
   logic [DATA_W-1:0]  carry_d;
   logic [DATA_W-1:0]  carry_q;
   logic [PW-1:0]      pos;
   logic               absorb;
   logic               load;

   sab_rate_sel #(
      .RB0(RATE_B0), .RB1(RATE_B1), .RB2(RATE_B2), .RB3(RATE_B3), .PW(PW)
   ) u_rate (
      .mode_i (mode_q),
      .rate_o (rate_b)
   );

   sab_lane_xor #(.SB(SB), .DB(DB), .PW(PW)) u_lane (
      .st_i    (st_q),
      .dat_i   (s_tdata_i),
      .keep_i  (s_tkeep_i),
      .pos_i   (pos),
      .rate_i  (rate_b),
      .st_o    (st_mix),
      .carry_o (carry_d)
   );

   sab_ctrl #(.DB(DB), .PW(PW)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start_i),
      .valid_i     (s_tvalid_i),
      .last_i      (s_tlast_i),
      .keep_i      (s_tkeep_i),
      .perm_done_i (perm_done_i),
      .rate_i      (rate_b),
      .ready_o     (s_tready_o),
      .perm_req_o  (perm_req_o),
      .done_o      (msg_done_o),
      .pos_o       (pos),
      .absorb_o    (absorb),
      .load_o      (load)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= '0;
         st_q    <= '0;
         carry_q <= '0;
      end else if (start_i) begin
         mode_q  <= mode_i;
         st_q    <= '0;
         carry_q <= '0;
      end else if (absorb) begin
         st_q    <= st_mix;
         carry_q <= carry_d;
      end else if (load) begin
         st_q    <= perm_state_i ^ {{(STATE_W-DATA_W){1'b0}}, carry_q};
      end
   end

   assign state_o    = st_q;
   assign byte_pos_o = pos;

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
      start_i |=> (state_o == '0 && byte_pos_o == '0 && s_tready_o));

   assert_hold_without_beat_R5: assert property (@(posedge clk) disable iff (rst)
      (!start_i && !(s_tvalid_i && s_tready_o) && !perm_done_i) |=> $stable(state_o));

   assert_done_closes_sink_R8: assert property (@(posedge clk) disable iff (rst)
      msg_done_o |-> !s_tready_o);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $past(rst) |-> (!s_tready_o && !perm_req_o && !msg_done_o));

endmodule

// File: tb/sim_sponge_absorb_unit.sv
`timescale 1ns/1ps
module sim_sponge_absorb_unit;

   localparam int DW = 256;
   localparam int SW = 1600;
   localparam int DB = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start_i = 1'b0;
   logic [1:0]    mode_i = 2'd0;
   logic [DW-1:0] s_tdata_i = '0;
   logic [DB-1:0] s_tkeep_i = '0;
   logic          s_tvalid_i = 1'b0;
   logic          s_tlast_i = 1'b0;
   logic          s_tready_o;
   logic          perm_req_o;
   logic          perm_done_i = 1'b0;
   logic [SW-1:0] perm_state_i;
   logic [SW-1:0] state_o;
   logic          msg_done_o;
   logic [7:0]    byte_pos_o;

   int checks = 0;
   int failures = 0;

   logic [SW-1:0] ref_st;
   int            ref_pos;
   int            ref_rate;
   logic [7:0]    carry_b [DB];
   int            carry_n;
   int            seed = 1;

   always #4 clk = ~clk;

   assign perm_state_i = ~state_o;   // stand-in permutation: invert every bit

   sponge_absorb_unit u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
      .s_tdata_i(s_tdata_i), .s_tkeep_i(s_tkeep_i), .s_tvalid_i(s_tvalid_i),
      .s_tlast_i(s_tlast_i), .s_tready_o(s_tready_o), .perm_req_o(perm_req_o),
      .perm_done_i(perm_done_i), .perm_state_i(perm_state_i), .state_o(state_o),
      .msg_done_o(msg_done_o), .byte_pos_o(byte_pos_o)
   );

   function automatic int rate_of(int m);
      case (m)
         0: return 136;
         1: return 72;
         2: return 168;
         default: return 136;
      endcase
   endfunction

   task automatic chk_val(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_state(string req, string what);
      checks++;
      if (state_o !== ref_st) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, state_o, ref_st);
      end
   endtask

   // called at a negedge with perm_req_o high
   task automatic do_perm();
      chk_val("R6", "ready while permuting", int'(s_tready_o), 0);
      @(negedge clk);
      chk_state("R5", "state held while permuting");
      chk_val("R5", "position held while permuting", int'(byte_pos_o), ref_pos);
      perm_done_i = 1'b1;
      @(negedge clk);
      perm_done_i = 1'b0;
      ref_st = ~ref_st;
      for (int j = 0; j < carry_n; j++) ref_st[j*8 +: 8] ^= carry_b[j];
      chk_state("R7", "permuted state with carry merged");
      chk_val("R7", "position after load", int'(byte_pos_o), ref_pos);
      chk_val("R6", "request drops after load", int'(perm_req_o), 0);
   endtask

   task automatic start_msg(int m);
      @(negedge clk);
      start_i = 1'b1;
      mode_i  = 2'(m);
      @(negedge clk);
      start_i = 1'b0;
      mode_i  = ~2'(m);   // must be ignored until the next start
      ref_st   = '0;
      ref_pos  = 0;
      ref_rate = rate_of(m);
      carry_n  = 0;
      chk_state("R2", "state cleared by start");
      chk_val("R2", "position cleared by start", int'(byte_pos_o), 0);
      chk_val("R2", "ready after start", int'(s_tready_o), 1);
   endtask

   // returns 1 when the beat filled the block
   task automatic send_beat(int n, bit last, output bit full);
      logic [7:0] d [DB];
      for (int i = 0; i < DB; i++) begin
         d[i] = (i < n) ? 8'((seed * 29 + i * 13 + 7) ^ (seed >> 3)) : (8'hA5 ^ 8'(i));
         s_tdata_i[i*8 +: 8] = d[i];
         s_tkeep_i[i] = (i < n);
      end
      seed++;
      s_tvalid_i = 1'b1;
      s_tlast_i  = last;
      while (!s_tready_o) begin
         if (perm_req_o) do_perm();
         else @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      s_tvalid_i = 1'b0;
      s_tlast_i  = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (ref_pos + i < ref_rate) ref_st[(ref_pos+i)*8 +: 8] ^= d[i];
         else carry_b[ref_pos + i - ref_rate] = d[i];
      end
      ref_pos += n;
      full = (ref_pos >= ref_rate);
      if (full) begin
         carry_n = ref_pos - ref_rate;
         ref_pos = carry_n;
      end else begin
         carry_n = 0;
      end
      chk_state("R3", "state after beat");
      chk_val("R4", "position after beat", int'(byte_pos_o), ref_pos);
      chk_val("R6", "request after beat", int'(perm_req_o), int'(full));
      chk_val("R8", "ready after beat", int'(s_tready_o), int'(!full && !last));
   endtask

   task automatic run_msg(int m, int n, int len);
      int sent = 0;
      bit full = 1'b0;
      string tag;
      start_msg(m);
      while (sent < len) begin
         int k = (len - sent < n) ? (len - sent) : n;
         send_beat(k, (sent + k == len), full);
         sent += k;
      end
      if (!full) tag = "R8";
      else if (carry_n == 0) tag = "R9";
      else tag = "R10";
      if (perm_req_o) do_perm();
      chk_val(tag, "done at end of message", int'(msg_done_o), 1);
      chk_val(tag, "pad byte position", int'(byte_pos_o), ref_pos);
      chk_val(tag, "ready closed when done", int'(s_tready_o), 0);
      chk_state(tag, "final state");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk_val("R1", "ready in reset", int'(s_tready_o), 0);
      chk_val("R1", "request in reset", int'(perm_req_o), 0);
      rst = 1'b0;
      s_tvalid_i = 1'b1;
      s_tkeep_i  = '1;
      s_tdata_i  = {8{32'hDEADBEEF}};
      repeat (3) @(negedge clk);
      chk_val("R1", "ready idle after reset", int'(s_tready_o), 0);
      chk_val("R1", "done idle after reset", int'(msg_done_o), 0);
      chk_val("R1", "state idle after reset", int'(state_o == '0), 1);
      s_tvalid_i = 1'b0;

      // R5: data present but valid low leaves the state alone
      start_msg(0);
      s_tkeep_i = '1;
      repeat (3) @(negedge clk);
      chk_state("R5", "no beat without valid");
      chk_val("R5", "position without valid", int'(byte_pos_o), 0);

      // R2: restart mid-message clears everything
      begin
         bit f;
         start_msg(1);
         send_beat(20, 1'b0, f);
         send_beat(20, 1'b0, f);
         start_msg(2);
      end

      // R3/R4/R7/R8/R9/R10: sweep all modes and beat widths
      for (int m = 0; m < 4; m++) begin
         for (int n = 1; n <= DB; n++) begin
            int r = rate_of(m);
            run_msg(m, n, r);
            run_msg(m, n, ((r + n - 1) / n) * n);
            run_msg(m, n, 2 * r + 5);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8ns * 200000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule